// File: doc/BRIEF.md
# Multi-lane SPI transaction engine

This block is a half-duplex SPI master that carries out one framed transaction at a time. Every frame starts with a 32-bit header sent on lane 0: the 8-bit command code first, then a 24-bit target address, both most significant bit first. A data phase of a programmable number of bytes follows. The command code sets the direction of the data phase and its width: one, two or four lanes. On a write the master drives the whole frame. On a read the master releases every lane once the header has gone out, and the device drives the data.

The host latches a command, an address, a byte count and a clock divider with a one-cycle start pulse. Write bytes are taken from a stream input, and each byte taken is acknowledged with a one-cycle pulse. Read bytes come back as one-cycle valid pulses. A one-cycle done pulse ends each transaction. The serial clock follows SPI mode 0: it idles low, outputs change when it falls and inputs are sampled when it rises. Chip select is active low and covers the whole frame.

Top module: `spi_lane_engine`

## Requirements
- R1: The header is 32 rising clock edges long and carries the command byte, then the address, MSB first on lane 0. During the header the output-enable vector is 4'b0001.
- R2: Command codes decode as 0x0B read x1, 0x02 write x1, 0xBB read x2, 0xB2 write x2, 0xEB read x4, 0xE2 write x4. Each data byte then takes 8, 4 or 2 clock periods.
- R3: Single-lane data is sent on lane 0 (io_o[0]), with enable 4'b0001, and is received on lane 1 (io_i[1]). Lanes 0, 2 and 3 are ignored on reads.
- R4: Dual-lane data moves two bits per clock, with the more significant bit on lane 1 (enable 4'b0011 on writes). Lanes 2 and 3 are ignored on reads.
- R5: Quad-lane data moves one nibble per clock on lanes 3..0, high nibble first (enable 4'b1111 on writes).
- R6: On a read, all output enables are 0 from the falling edge after the 32nd header bit until the end of the frame. The output-enable vector is always one of 0000, 0001, 0011 or 1111.
- R7: The serial clock is low whenever chip select is high. Lane outputs and enables never change while the serial clock stays high.
- R8: Each serial clock half period lasts div_i+1 system clock cycles, including the half period from chip select falling to the first rising edge.
- R9: After reset, cs_n_o is 1, sclk_o is 0, all enables are 0 and done_o is 0. done_o pulses for exactly one cycle, with chip select high and the clock low, right after the last falling edge.
- R10: A command outside the R2 table produces done_o together with err_o, and no serial clock edge or chip select assertion.
- R11: A byte count of zero sends only the 32-bit header, then completes.
- R12: A start pulse received while a frame is in progress is ignored. The running frame completes unchanged.
- R13: A write takes exactly nbytes_i bytes from wr_data_i, each acknowledged by one wr_take_o pulse. A frame has exactly 32 + nbytes_i*(8/lanes) rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a frame |
| cmd_i | input | 8 | Command code, latched at start |
| addr_i | input | 24 | Target address, latched at start |
| nbytes_i | input | CNT_W | Data byte count, latched at start |
| div_i | input | DIV_W | Half-period length minus one, in system clocks |
| wr_data_i | input | 8 | Current write byte of the stream |
| wr_take_o | output | 1 | Pulse: the current write byte was taken |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | Pulse: rd_data_o holds a new byte |
| done_o | output | 1 | Pulse: transaction finished |
| err_o | output | 1 | Qualifies done_o: command code not recognised |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| io_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Lane output enables |
| io_i | input | 4 | Lane input values |

## Verification
All six valid commands are run against a device model, at different divider settings and with distinct byte patterns. On reads the model places inverted or unrelated values on the lanes that the selected width must ignore. A lane-order or nibble-order swap therefore changes the received bytes, and so does sampling the wrong lane. Zero-length writes and reads show that the header stands alone. An unknown code separates the error path from a normal completion. A second start pulse in the middle of a quad write shows that the frame in progress keeps its latched settings.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;

  // Data-phase lane width selected by the command code
  typedef enum logic [1:0] {
    LW_X1 = 2'd0,
    LW_X2 = 2'd1,
    LW_X4 = 2'd2
  } lane_w_e;

  // Latched meaning of a command code
  typedef struct packed {
    logic    rd;
    lane_w_e width;
  } cmd_info_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_FIN  = 2'd3
  } phase_e;

  localparam int CMD_W = 8;

  // Clock periods needed to move one byte at a given width
  function automatic logic [3:0] periods_per_byte(lane_w_e w);
    unique case (w)
      LW_X2:   return 4'd4;
      LW_X4:   return 4'd2;
      default: return 4'd8;
    endcase
  endfunction

  // Output enables for a write data phase
  function automatic logic [3:0] lane_mask(lane_w_e w);
    unique case (w)
      LW_X2:   return 4'b0011;
      LW_X4:   return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_lane_pkg::*;
#(
  parameter logic [7:0] OP_RD_X1 = 8'h0B,
  parameter logic [7:0] OP_WR_X1 = 8'h02,
  parameter logic [7:0] OP_RD_X2 = 8'hBB,
  parameter logic [7:0] OP_WR_X2 = 8'hB2,
  parameter logic [7:0] OP_RD_X4 = 8'hEB,
  parameter logic [7:0] OP_WR_X4 = 8'hE2
) (
  input  logic [CMD_W-1:0] cmd_i,
  output logic             valid_o,
  output cmd_info_t        info_o
);

  always_comb begin
    valid_o      = 1'b1;
    info_o.rd    = 1'b0;
    info_o.width = LW_X1;
    unique case (cmd_i)
      OP_RD_X1: info_o.rd = 1'b1;
      OP_WR_X1: info_o.rd = 1'b0;
      OP_RD_X2: begin info_o.rd = 1'b1; info_o.width = LW_X2; end
      OP_WR_X2: info_o.width = LW_X2;
      OP_RD_X4: begin info_o.rd = 1'b1; info_o.width = LW_X4; end
      OP_WR_X4: info_o.width = LW_X4;
      default:  valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             hit;

  always_comb begin
    hit    = run_i && (cnt_q == div_i);
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (hit) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = hit & ~sclk_q;
  assign fall_o = hit & sclk_q;

endmodule

// File: rtl/spi_lane_engine.sv
module spi_lane_engine
  import spi_lane_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_take_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             err_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe_o,
  input  logic [3:0]       io_i
);

  localparam int HDR_BITS = CMD_W + ADDR_W;
  localparam int BEAT_W   = $clog2(HDR_BITS + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  phase_e                st_q, st_d;
  cmd_info_t             info_q, info_d;
  logic [DIV_W-1:0]      div_q, div_d;
  logic [HDR_BITS-1:0]   hdr_q, hdr_d;
  logic [7:0]            dat_q, dat_d;
  logic [7:0]            rx_q, rx_d;
  logic [7:0]            rdat_q, rdat_d;
  logic [BEAT_W-1:0]     beat_q, beat_d;
  logic [CNT_W-1:0]      left_q, left_d;
  logic                  err_q, err_d;
  logic                  take_q, take_d;
  logic                  rdv_q, rdv_d;

  logic                  dec_valid;
  cmd_info_t             dec_info;
  logic                  run, rise, fall;
  logic [7:0]            rx_shift, tx_shift;
  logic [BEAT_W-1:0]     per_byte;

  spi_cmd_decode u_dec (
    .cmd_i   (cmd_i),
    .valid_o (dec_valid),
    .info_o  (dec_info)
  );

  assign run = (st_q == ST_HDR) || (st_q == ST_DATA);

  spi_sclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk    (clk),
    .rst_n  (rst_s_q),
    .run_i  (run),
    .div_i  (div_q),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign per_byte = BEAT_W'(periods_per_byte(info_q.width));

  // lane-width dependent shifting, MSB first
  always_comb begin
    unique case (info_q.width)
      LW_X2: begin
        rx_shift = {rx_q[5:0], io_i[1:0]};
        tx_shift = {dat_q[5:0], 2'b00};
      end
      LW_X4: begin
        rx_shift = {rx_q[3:0], io_i[3:0]};
        tx_shift = {dat_q[3:0], 4'b0000};
      end
      default: begin
        rx_shift = {rx_q[6:0], io_i[1]};
        tx_shift = {dat_q[6:0], 1'b0};
      end
    endcase
  end

  // next state
  always_comb begin
    st_d   = st_q;
    info_d = info_q;
    div_d  = div_q;
    hdr_d  = hdr_q;
    dat_d  = dat_q;
    rx_d   = rx_q;
    rdat_d = rdat_q;
    beat_d = beat_q;
    left_d = left_q;
    err_d  = err_q;
    take_d = 1'b0;
    rdv_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          info_d = dec_info;
          div_d  = div_i;
          left_d = nbytes_i;
          hdr_d  = {cmd_i, addr_i};
          beat_d = '0;
          err_d  = ~dec_valid;
          st_d   = dec_valid ? ST_HDR : ST_FIN;
        end
      end
      ST_HDR: begin
        if (rise) begin
          beat_d = beat_q + 1'b1;
        end
        if (fall) begin
          if (beat_q == BEAT_W'(HDR_BITS)) begin
            beat_d = '0;
            if (left_q == '0) begin
              st_d = ST_FIN;
            end else begin
              st_d = ST_DATA;
              if (!info_q.rd) begin
                dat_d  = wr_data_i;
                take_d = 1'b1;
              end
            end
          end else begin
            hdr_d = {hdr_q[HDR_BITS-2:0], 1'b0};
          end
        end
      end
      ST_DATA: begin
        if (rise) begin
          beat_d = beat_q + 1'b1;
          if (info_q.rd) begin
            rx_d = rx_shift;
            if (beat_q + 1'b1 == per_byte) begin
              rdat_d = rx_shift;
              rdv_d  = 1'b1;
            end
          end
        end
        if (fall) begin
          if (beat_q == per_byte) begin
            beat_d = '0;
            if (left_q == CNT_W'(1)) begin
              st_d = ST_FIN;
            end else begin
              left_d = left_q - 1'b1;
              if (!info_q.rd) begin
                dat_d  = wr_data_i;
                take_d = 1'b1;
              end
            end
          end else if (!info_q.rd) begin
            dat_d = tx_shift;
          end
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      st_q   <= ST_IDLE;
      info_q <= '0;
      div_q  <= '0;
      hdr_q  <= '0;
      dat_q  <= '0;
      rx_q   <= '0;
      rdat_q <= '0;
      beat_q <= '0;
      left_q <= '0;
      err_q  <= 1'b0;
      take_q <= 1'b0;
      rdv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      info_q <= info_d;
      div_q  <= div_d;
      hdr_q  <= hdr_d;
      dat_q  <= dat_d;
      rx_q   <= rx_d;
      rdat_q <= rdat_d;
      beat_q <= beat_d;
      left_q <= left_d;
      err_q  <= err_d;
      take_q <= take_d;
      rdv_q  <= rdv_d;
    end
  end

  // lane drive, all from registered state
  always_comb begin
    io_o    = 4'b0000;
    io_oe_o = 4'b0000;
    if (st_q == ST_HDR) begin
      io_o    = {3'b000, hdr_q[HDR_BITS-1]};
      io_oe_o = 4'b0001;
    end else if (st_q == ST_DATA && !info_q.rd) begin
      io_oe_o = lane_mask(info_q.width);
      unique case (info_q.width)
        LW_X2:   io_o = {2'b00, dat_q[7:6]};
        LW_X4:   io_o = dat_q[7:4];
        default: io_o = {3'b000, dat_q[7]};
      endcase
    end
  end

  assign cs_n_o     = ~run;
  assign done_o     = (st_q == ST_FIN);
  assign err_o      = (st_q == ST_FIN) & err_q;
  assign wr_take_o  = take_q;
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rdat_q;

endmodule

// File: rtl/spi_lane_engine_chk.sv
module spi_lane_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input logic       done,
  input logic       err,
  input logic [2:0] info
);

  // R7: clock parked low outside a frame
  p_clock_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R7: nothing on the lanes moves while the clock stays high
  p_stable_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> ($stable(io_out) && $stable(io_oe)));

  // R6: only legal enable shapes, never mixed directions
  p_oe_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

  // R9: lanes released between frames
  p_oe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done only with the bus quiet
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !sclk));

  // R10: the error flag only qualifies a done pulse
  p_err_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R12: a start during a frame leaves the latched command alone
  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && start_i) |=> $stable(info));

endmodule

bind spi_lane_engine spi_lane_engine_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .cs_n    (cs_n_o),
  .sclk    (sclk_o),
  .io_out  (io_o),
  .io_oe   (io_oe_o),
  .done    (done_o),
  .err     (err_o),
  .info    (info_q)
);

// File: tb/sim_spi_lane_engine.sv
module sim_spi_lane_engine;

  localparam int CNT_W = 8;
  localparam int DIV_W = 8;

  // 125 MHz: 8-unit period
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [7:0]       cmd_i = '0;
  logic [23:0]      addr_i = '0;
  logic [CNT_W-1:0] nbytes_i = '0;
  logic [DIV_W-1:0] div_i = '0;
  logic [7:0]       wr_data_i;
  logic             wr_take_o, rd_valid_o, done_o, err_o, cs_n_o, sclk_o;
  logic [7:0]       rd_data_o;
  logic [3:0]       io_o, io_oe_o;
  logic [3:0]       io_i = 4'h0;

  spi_lane_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .addr_i(addr_i),
    .nbytes_i(nbytes_i), .div_i(div_i), .wr_data_i(wr_data_i), .wr_take_o(wr_take_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .done_o(done_o), .err_o(err_o),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .io_o(io_o), .io_oe_o(io_oe_o), .io_i(io_i)
  );

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  logic [31:0] hdr_exp[$];
  logic [7:0]  wr_exp[$];
  logic [7:0]  rd_exp[$];

  int          cur_w = 1;
  bit          cur_rd = 0;
  logic [7:0]  cur_seed = 8'h00;
  int          cur_div = 0;
  logic [7:0]  wr_idx = 8'h00;
  bit          clr_idx = 0;

  function automatic logic [7:0] wpat(input logic [7:0] s, input logic [7:0] k);
    return (s ^ 8'h96) + k * 8'd53;
  endfunction

  function automatic logic [7:0] rpat(input logic [7:0] s, input logic [7:0] k);
    return (s ^ 8'h5A) + k * 8'd71;
  endfunction

  function automatic string lane_req(input int w);
    if (w == 1) return "R3";
    if (w == 2) return "R4";
    return "R5";
  endfunction

  function automatic logic [3:0] oe_mask(input int w);
    if (w == 1) return 4'b0001;
    if (w == 2) return 4'b0011;
    return 4'b1111;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // write stream source
  always @(posedge clk) begin
    if (clr_idx) wr_idx <= 8'h00;
    else if (wr_take_o) wr_idx <= wr_idx + 8'd1;
  end
  assign wr_data_i = wpat(cur_seed, wr_idx);

  // device model and monitor, sampled on the falling system clock
  int          rise_cnt = 0;
  int          hp_cnt = 0;
  bit          prev_sclk = 0;
  bit          hp_bad = 0;
  bit          oe_bad = 0;
  logic [31:0] hdr_acc = '0;
  logic [7:0]  wacc = '0;

  always @(negedge clk) begin
    if (start_i && cs_n_o) begin
      rise_cnt = 0; hp_cnt = 0; hp_bad = 0; oe_bad = 0; hdr_acc = '0; wacc = '0;
    end
    hp_cnt++;
    if (sclk_o && !prev_sclk) begin
      hp_cnt = 0;
      rise_cnt++;
      if (rise_cnt <= 32) begin
        if (io_oe_o != 4'b0001) oe_bad = 1;
        hdr_acc = {hdr_acc[30:0], io_o[0]};
        if (rise_cnt == 32) begin
          if (hdr_exp.size() == 0) check(0, "R1", "unexpected header", hdr_acc, 0);
          else begin
            logic [31:0] e;
            e = hdr_exp.pop_front();
            check(hdr_acc == e, "R1", "header bits", hdr_acc, e);
          end
        end
      end else if (cur_rd) begin
        if (io_oe_o != 4'b0000) oe_bad = 1;
      end else begin
        int b;
        if (io_oe_o != oe_mask(cur_w)) oe_bad = 1;
        if (cur_w == 1) wacc = {wacc[6:0], io_o[0]};
        else if (cur_w == 2) wacc = {wacc[5:0], io_o[1:0]};
        else wacc = {wacc[3:0], io_o};
        b = rise_cnt - 33;
        if (((b + 1) % (8 / cur_w)) == 0) begin
          if (wr_exp.size() == 0) check(0, "R13", "extra write byte", wacc, 0);
          else begin
            logic [7:0] e;
            e = wr_exp.pop_front();
            check(wacc == e, lane_req(cur_w), "write byte on lanes", wacc, e);
          end
        end
      end
    end else if (!sclk_o && prev_sclk) begin
      if (hp_cnt != cur_div + 1) hp_bad = 1;
      hp_cnt = 0;
      if (cur_rd && rise_cnt >= 32) begin
        int b, bpb, k, s;
        logic [7:0] byt;
        b = rise_cnt - 32;
        bpb = 8 / cur_w;
        k = b / bpb;
        s = b % bpb;
        byt = rpat(cur_seed, k[7:0]);
        if (cur_w == 1) io_i = {1'b1, 1'b0, byt[7-s], ~byt[7-s]};
        else if (cur_w == 2) io_i = {~byt[6-2*s], ~byt[7-2*s], byt[7-2*s], byt[6-2*s]};
        else io_i = (s == 0) ? byt[7:4] : byt[3:0];
      end
    end else if (sclk_o) begin
      if (hp_cnt > cur_div + 1) hp_bad = 1;
    end
    if (rd_valid_o) begin
      if (rd_exp.size() == 0) check(0, "R6", "unexpected read byte", rd_data_o, 0);
      else begin
        logic [7:0] e;
        e = rd_exp.pop_front();
        check(rd_data_o == e, lane_req(cur_w), "read byte from lanes", rd_data_o, e);
      end
    end
    prev_sclk = sclk_o;
  end

  task automatic run_frame(input logic [7:0] cmd, input logic [23:0] addr, input int n,
                           input int dv, input int w, input bit rd, input bit ok,
                           input logic [7:0] seed, input bit poke);
    int cyc;
    int exp_rises;
    @(posedge clk); #2;
    cur_w = w; cur_rd = rd; cur_seed = seed; cur_div = dv; clr_idx = 1;
    if (ok) begin
      hdr_exp.push_back({cmd, addr});
      for (int k = 0; k < n; k++) begin
        if (rd) rd_exp.push_back(rpat(seed, k[7:0]));
        else wr_exp.push_back(wpat(seed, k[7:0]));
      end
    end
    cmd_i = cmd; addr_i = addr; nbytes_i = n[CNT_W-1:0]; div_i = dv[DIV_W-1:0]; start_i = 1;
    @(posedge clk); #2;
    start_i = 0; clr_idx = 0;
    if (poke) begin
      repeat (20) @(posedge clk);
      #2;
      cmd_i = 8'h55; nbytes_i = '0; div_i = 8'd0; start_i = 1;
      @(posedge clk); #2;
      start_i = 0;
    end
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (done_o || cyc > 20000) break;
    end
    check(done_o == 1'b1, "R9", "done pulse seen", done_o, 1);
    exp_rises = ok ? 32 + n * (8 / w) : 0;
    check(err_o == !ok, ok ? "R2" : "R10", "error flag", err_o, !ok);
    check(rise_cnt == exp_rises, !ok ? "R10" : (n == 0 ? "R11" : "R13"),
          "rising edges in frame", rise_cnt, exp_rises);
    check(cs_n_o && !sclk_o, "R9", "bus quiet at done", {cs_n_o, sclk_o}, 2'b10);
    if (ok) begin
      check(!hp_bad, "R8", "half period length", hp_bad, 0);
      check(!oe_bad, rd ? "R6" : "R1", "output enable pattern", oe_bad, 0);
    end
    @(negedge clk);
    check(done_o == 1'b0, "R9", "done width", done_o, 0);
    check(hdr_exp.size() + wr_exp.size() + rd_exp.size() == 0, poke ? "R12" : "R13",
          "scoreboard drained", hdr_exp.size() + wr_exp.size() + rd_exp.size(), 0);
    hdr_exp.delete(); wr_exp.delete(); rd_exp.delete();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cs_n_o == 1'b1, "R9", "reset chip select", cs_n_o, 1);
    check(sclk_o == 1'b0, "R7", "reset clock level", sclk_o, 0);
    check(io_oe_o == 4'b0000, "R9", "reset enables", io_oe_o, 0);
    check(done_o == 1'b0, "R9", "reset done", done_o, 0);

    run_frame(8'h02, 24'h123456, 3, 1, 1, 0, 1, 8'h11, 0); // R3 single write
    run_frame(8'hB2, 24'hA5C3F0, 2, 0, 2, 0, 1, 8'h22, 0); // R4 dual write
    run_frame(8'hE2, 24'h00FF81, 4, 2, 4, 0, 1, 8'h33, 0); // R5 quad write
    run_frame(8'h0B, 24'h7E0001, 3, 1, 1, 1, 1, 8'h44, 0); // R3 single read
    run_frame(8'hBB, 24'h800000, 2, 0, 2, 1, 1, 8'h55, 0); // R4 dual read
    run_frame(8'hEB, 24'h0C0C0C, 5, 3, 4, 1, 1, 8'h66, 0); // R5 quad read
    run_frame(8'h02, 24'hFEDCBA, 0, 1, 1, 0, 1, 8'h77, 0); // R11 zero write
    run_frame(8'hEB, 24'h135790, 0, 0, 4, 1, 1, 8'h88, 0); // R11 zero read
    run_frame(8'h55, 24'h000001, 2, 1, 1, 0, 0, 8'h99, 0); // R10 unknown code
    run_frame(8'hE2, 24'h2468AC, 4, 2, 4, 0, 1, 8'hAA, 1); // R12 start while busy

    summary();
    finished = 1;
    $finish;
  end

endmodule